// File: doc/BRIEF.md
# PHY Management Register Model

This block models the register space of an Ethernet PHY as software sees it through a management controller. It does not model the serial pins. Software drives it with two words: a data word and a command word. Writing the command word decodes three things: the target PHY address, the register number and the direction. The block then acts at once. A write command copies the held data word into the selected PHY register. A read command loads the selected PHY register into the data word.

The register set holds a control word, a status word, two identifier words, an advertisement word and a link-partner ability word. The status word carries a link-up flag taken from an external input. That input passes through a small synchronizer first.

A command whose PHY address does not match the strap input does nothing. The capability and identifier values are fixed. Bit 15 of the control word is a self-clearing reset: writing it restores the control and advertisement words to their defaults. The busy flag of the stored command always reads back as 0, so polling software never waits.

Top module: `phy_mgmt_model`

## Requirements
- R1: After reset, the command and data words are 0, the control register (number 0) reads 0x3100 and the advertisement register (number 4) reads 0x0000.
- R2: The command word has these fields: PHY address in bits [15:12], register number in bits [7:4], direction in bit 1 (1 = write, 0 = read) and busy in bit 0. It is stored as written except that bit 0 is forced to 0. The stored value is visible on `cmd_q` after the clock edge that accepted it.
- R3: A command whose bits [15:12] differ from `phy_addr_i` leaves the data word and every PHY register unchanged.
- R4: The status register (number 1) reads 0xFE28 with bit 2 set when the synchronized link input is high.
- R5: A change of the link input alters only status bit 2. It reaches that bit after `SYNC_STAGES` clock edges and leaves the other registers unchanged.
- R6: A write to the control register with data bit 15 clear stores the data with bits 15 and 9 forced to 0.
- R7: A write to the control register with data bit 15 set restores control to 0x3100 and advertisement to 0x0000. The link bit in status is kept.
- R8: Register 2 reads 0x0044, register 3 reads 0x1400 and register 5 reads 0x0DE0. Writes to these three registers change nothing.
- R9: Register 4 stores any 16-bit value written to it and reads it back unchanged.
- R10: Registers 6 to 15 read as 0, and writes to them are ignored. Writes to the status register are ignored too.
- R11: A matching read command loads the data word on the same edge that stores the command. A direct data write in that same cycle loses to the read result.
- R12: A write command uses the data word held before its edge and leaves the data word unchanged.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| phy_addr_i | input | 4 | Configured PHY address this model answers to |
| link_up_i | input | 1 | Asynchronous link-up indication |
| cmd_wr | input | 1 | Write strobe for the command word |
| cmd_wdata | input | 16 | Command word to write |
| data_wr | input | 1 | Write strobe for the data word |
| data_wdata | input | 16 | Data word to write |
| cmd_q | output | 16 | Stored command word |
| data_q | output | 16 | Stored data word |

## Verification
Every command takes effect on the single clock edge that accepts it. The resulting `cmd_q` and `data_q` values, and any register update, are due one edge after the strobe. The bench drives strobes on the falling edge and samples on the next falling edge. A read issued right after a write therefore observes the write. The link flag takes `SYNC_STAGES` edges to reach status bit 2, so the bench waits more than that before it reads status.

// File: rtl/phy_mgmt_pkg.sv
package phy_mgmt_pkg;

  localparam int unsigned WORD_W   = 16;
  localparam int unsigned ADDR_W   = 4;
  localparam int unsigned REGN_W   = 4;
  localparam int unsigned NUM_REGS = 1 << REGN_W;

  // command word field positions (software decodes these)
  localparam int unsigned ADDR_LSB = 12;
  localparam int unsigned REGN_LSB = 4;
  localparam int unsigned DIR_BIT  = 1;
  localparam int unsigned BUSY_BIT = 0;

  // register numbers
  localparam int unsigned RN_CTRL    = 0;
  localparam int unsigned RN_STAT    = 1;
  localparam int unsigned RN_ID_HI   = 2;
  localparam int unsigned RN_ID_LO   = 3;
  localparam int unsigned RN_ADV     = 4;
  localparam int unsigned RN_PARTNER = 5;

  typedef logic [WORD_W-1:0] word_t;
  typedef logic [REGN_W-1:0] regn_t;
  typedef logic [ADDR_W-1:0] phy_t;

  localparam word_t CTRL_DEFAULT = 16'h3100;
  localparam word_t ADV_DEFAULT  = 16'h0000;
  localparam word_t STAT_BASE    = 16'hFE28;
  localparam word_t ID_HI_VAL    = 16'h0044;
  localparam word_t ID_LO_VAL    = 16'h1400;
  localparam word_t PARTNER_VAL  = 16'h0DE0;

  localparam int unsigned CTRL_RST_BIT     = 15;
  localparam int unsigned CTRL_RESTART_BIT = 9;
  localparam int unsigned STAT_LINK_BIT    = 2;

  typedef struct packed {
    phy_t  phy;
    regn_t regn;
    logic  wr;
  } cmd_t;

  function automatic cmd_t split_cmd(input word_t w);
    cmd_t c;
    c.phy  = w[ADDR_LSB +: ADDR_W];
    c.regn = w[REGN_LSB +: REGN_W];
    c.wr   = w[DIR_BIT];
    return c;
  endfunction

  function automatic word_t clear_busy(input word_t w);
    word_t r;
    r = w;
    r[BUSY_BIT] = 1'b0;
    return r;
  endfunction

  function automatic word_t ctrl_store(input word_t d);
    word_t r;
    r = d;
    r[CTRL_RST_BIT]     = 1'b0;
    r[CTRL_RESTART_BIT] = 1'b0;
    return r;
  endfunction

  function automatic word_t stat_value(input logic link);
    word_t r;
    r = STAT_BASE;
    r[STAT_LINK_BIT] = link;
    return r;
  endfunction

  // contents of register slot idx
  function automatic word_t slot_word(input int unsigned idx, input word_t ctrl,
                                      input word_t adv, input logic link);
    case (idx)
      RN_CTRL:    return ctrl;
      RN_STAT:    return stat_value(link);
      RN_ID_HI:   return ID_HI_VAL;
      RN_ID_LO:   return ID_LO_VAL;
      RN_ADV:     return adv;
      RN_PARTNER: return PARTNER_VAL;
      default:    return '0;
    endcase
  endfunction

endpackage

// File: rtl/phy_cmd_decode.sv
module phy_cmd_decode
  import phy_mgmt_pkg::*;
(
  input  logic  cmd_wr,
  input  word_t cmd_wdata,
  input  phy_t  phy_addr,
  output logic  hit,
  output logic  rd_go,
  output logic  wr_go,
  output regn_t regn
);
  cmd_t c;

  always_comb begin
    c     = split_cmd(cmd_wdata);
    regn  = c.regn;
    hit   = cmd_wr && (c.phy == phy_addr);
    rd_go = hit && !c.wr;
    wr_go = hit && c.wr;
  end
endmodule

// File: rtl/phy_link_sync.sv
module phy_link_sync #(
  parameter int unsigned STAGES = 2
) (
  input  logic clk,
  input  logic rst_n,
  input  logic din,
  output logic dout
);
  logic [STAGES-1:0] sr;

  for (genvar g = 0; g < STAGES; g++) begin : g_stage
    if (g == 0) begin : g_first
      always_ff @(posedge clk) begin
        if (!rst_n) sr[g] <= 1'b0;
        else        sr[g] <= din;
      end
    end else begin : g_next
      always_ff @(posedge clk) begin
        if (!rst_n) sr[g] <= 1'b0;
        else        sr[g] <= sr[g-1];
      end
    end
  end

  assign dout = sr[STAGES-1];
endmodule

// File: rtl/phy_reg_file.sv
module phy_reg_file
  import phy_mgmt_pkg::*;
(
  input  logic  clk,
  input  logic  rst_n,
  input  logic  wr_go,
  input  regn_t regn,
  input  word_t wdata,
  input  logic  link,
  output word_t rd_value,
  output logic  ctrl_reset_ev
);
  word_t ctrl_q;
  word_t adv_q;
  word_t slot_val [NUM_REGS];
  logic  ctrl_sel;
  logic  adv_sel;

  assign ctrl_sel      = wr_go && (regn == regn_t'(RN_CTRL));
  assign adv_sel       = wr_go && (regn == regn_t'(RN_ADV));
  assign ctrl_reset_ev = ctrl_sel && wdata[CTRL_RST_BIT];

  always_ff @(posedge clk) begin
    if (!rst_n || ctrl_reset_ev) begin
      ctrl_q <= CTRL_DEFAULT;
      adv_q  <= ADV_DEFAULT;
    end else begin
      if (ctrl_sel) ctrl_q <= ctrl_store(wdata);
      if (adv_sel)  adv_q  <= wdata;
    end
  end

  for (genvar g = 0; g < NUM_REGS; g++) begin : g_slot
    assign slot_val[g] = (regn == regn_t'(g)) ?
                         slot_word(g, ctrl_q, adv_q, link) : '0;
  end

  always_comb begin
    rd_value = '0;
    for (int i = 0; i < NUM_REGS; i++) rd_value = rd_value | slot_val[i];
  end
endmodule

// File: rtl/phy_mgmt_model.sv
module phy_mgmt_model
  import phy_mgmt_pkg::*;
#(
  parameter int unsigned SYNC_STAGES = 2
) (
  input  logic        clk,
  input  logic        rst_n,
  input  logic [3:0]  phy_addr_i,
  input  logic        link_up_i,
  input  logic        cmd_wr,
  input  logic [15:0] cmd_wdata,
  input  logic        data_wr,
  input  logic [15:0] data_wdata,
  output logic [15:0] cmd_q,
  output logic [15:0] data_q
);
  logic  cmd_hit;
  logic  rd_go;
  logic  wr_go;
  regn_t cmd_regn;
  word_t rd_value;
  logic  link_sync;
  logic  ctrl_reset_ev;

  phy_cmd_decode u_dec (
    .cmd_wr    (cmd_wr),
    .cmd_wdata (cmd_wdata),
    .phy_addr  (phy_addr_i),
    .hit       (cmd_hit),
    .rd_go     (rd_go),
    .wr_go     (wr_go),
    .regn      (cmd_regn)
  );

  phy_link_sync #(.STAGES(SYNC_STAGES)) u_link (
    .clk   (clk),
    .rst_n (rst_n),
    .din   (link_up_i),
    .dout  (link_sync)
  );

  phy_reg_file u_regs (
    .clk           (clk),
    .rst_n         (rst_n),
    .wr_go         (wr_go),
    .regn          (cmd_regn),
    .wdata         (data_q),
    .link          (link_sync),
    .rd_value      (rd_value),
    .ctrl_reset_ev (ctrl_reset_ev)
  );

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      cmd_q  <= '0;
      data_q <= '0;
    end else begin
      if (cmd_wr)     cmd_q <= clear_busy(cmd_wdata);
      if (rd_go)      data_q <= rd_value;
      else if (data_wr) data_q <= data_wdata;
    end
  end
endmodule

// File: rtl/phy_mgmt_chk.sv
module phy_mgmt_chk (
  input logic        clk,
  input logic        rst_n,
  input logic [3:0]  phy_addr_i,
  input logic        cmd_wr,
  input logic [15:0] cmd_wdata,
  input logic        data_wr,
  input logic [15:0] cmd_q,
  input logic [15:0] data_q,
  input logic        cmd_hit,
  input logic        rd_go,
  input logic        wr_go
);
  // R2
  busy_clear_chk: assert property (@(posedge clk) disable iff (!rst_n)
    cmd_wr |=> (cmd_q == ($past(cmd_wdata) & 16'hFFFE)));

  // R3
  foreign_addr_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (cmd_wr && cmd_wdata[15:12] != phy_addr_i && !data_wr) |=> $stable(data_q));

  // R3
  hit_match_chk: assert property (@(posedge clk) disable iff (!rst_n)
    cmd_hit |-> (cmd_wdata[15:12] == phy_addr_i));

  // R11
  id_read_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (rd_go && cmd_wdata[7:4] == 4'd2) |=> (data_q == 16'h0044));

  // R12
  write_keeps_data_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (wr_go && !data_wr) |=> $stable(data_q));

  // R4
  status_shape_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (rd_go && cmd_wdata[7:4] == 4'd1) |=> ((data_q & 16'hFFFB) == 16'hFE28));
endmodule

bind phy_mgmt_model phy_mgmt_chk i_chk (
  .clk        (clk),
  .rst_n      (rst_n),
  .phy_addr_i (phy_addr_i),
  .cmd_wr     (cmd_wr),
  .cmd_wdata  (cmd_wdata),
  .data_wr    (data_wr),
  .cmd_q      (cmd_q),
  .data_q     (data_q),
  .cmd_hit    (cmd_hit),
  .rd_go      (rd_go),
  .wr_go      (wr_go)
);

// File: tb/test_phy_mgmt_model.sv
module test_phy_mgmt_model;
  localparam int CLK_P = 10;
  localparam logic [3:0] MY_PHY = 4'h5;

  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        link_up_i = 1'b0;
  logic        cmd_wr = 1'b0;
  logic [15:0] cmd_wdata = '0;
  logic        data_wr = 1'b0;
  logic [15:0] data_wdata = '0;
  logic [15:0] cmd_q;
  logic [15:0] data_q;
  int total = 0;
  int bad = 0;
  bit finished = 0;

  always #(CLK_P/2) clk = ~clk;

  phy_mgmt_model i_phy_mgmt_model (
    .clk        (clk),
    .rst_n      (rst_n),
    .phy_addr_i (MY_PHY),
    .link_up_i  (link_up_i),
    .cmd_wr     (cmd_wr),
    .cmd_wdata  (cmd_wdata),
    .data_wr    (data_wr),
    .data_wdata (data_wdata),
    .cmd_q      (cmd_q),
    .data_q     (data_q)
  );

  task automatic check(input string tag, input logic [15:0] act, input logic [15:0] exp);
    total++;
    if (act !== exp) begin
      bad++;
      $display("FAIL %s: actual=%h expected=%h", tag, act, exp);
    end
  endtask

  function automatic logic [15:0] mk_cmd(input logic [3:0] phy, input logic [3:0] rn,
                                         input logic wr);
    return {phy, 4'h0, rn, 2'b00, wr, 1'b1};
  endfunction

  task automatic do_cmd(input logic [3:0] phy, input logic [3:0] rn, input logic wr);
    @(negedge clk);
    cmd_wdata = mk_cmd(phy, rn, wr);
    cmd_wr = 1'b1;
    @(negedge clk);
    cmd_wr = 1'b0;
  endtask

  task automatic set_data(input logic [15:0] v);
    @(negedge clk);
    data_wdata = v;
    data_wr = 1'b1;
    @(negedge clk);
    data_wr = 1'b0;
  endtask

  task automatic read_reg(input logic [3:0] rn, output logic [15:0] v);
    do_cmd(MY_PHY, rn, 1'b0);
    v = data_q;
  endtask

  task automatic write_reg(input logic [3:0] rn, input logic [15:0] v);
    set_data(v);
    do_cmd(MY_PHY, rn, 1'b1);
  endtask

  task automatic t_reset();
    logic [15:0] v;
    check("R1 cmd", cmd_q, 16'h0000);
    check("R1 data", data_q, 16'h0000);
    read_reg(4'd0, v); check("R1 ctrl", v, 16'h3100);
    read_reg(4'd4, v); check("R1 adv", v, 16'h0000);
  endtask

  task automatic t_foreign();
    logic [15:0] v;
    set_data(16'hABCD);
    do_cmd(4'h9, 4'd2, 1'b0);
    check("R2 busy cleared", cmd_q, mk_cmd(4'h9, 4'd2, 1'b0) & 16'hFFFE);
    check("R3 data kept", data_q, 16'hABCD);
    do_cmd(4'h9, 4'd4, 1'b1);
    read_reg(4'd4, v); check("R3 adv untouched", v, 16'h0000);
  endtask

  task automatic t_link();
    logic [15:0] v;
    link_up_i = 1'b1;
    repeat (4) @(negedge clk);
    read_reg(4'd1, v); check("R4 status up", v, 16'hFE2C);
    link_up_i = 1'b0;
    repeat (4) @(negedge clk);
    read_reg(4'd1, v); check("R5 status down", v, 16'hFE28);
    read_reg(4'd0, v); check("R5 ctrl unaffected", v, 16'h3100);
  endtask

  task automatic t_ctrl();
    logic [15:0] v;
    write_reg(4'd0, 16'h7FFF);
    read_reg(4'd0, v); check("R6 ctrl masked", v, 16'h7DFF);
    link_up_i = 1'b1;
    repeat (4) @(negedge clk);
    write_reg(4'd4, 16'h01E1);
    write_reg(4'd0, 16'h8000);
    read_reg(4'd0, v); check("R7 ctrl default", v, 16'h3100);
    read_reg(4'd4, v); check("R7 adv default", v, 16'h0000);
    read_reg(4'd1, v); check("R7 link kept", v, 16'hFE2C);
  endtask

  task automatic t_fixed();
    logic [15:0] v;
    write_reg(4'd2, 16'hFFFF);
    write_reg(4'd3, 16'hFFFF);
    write_reg(4'd5, 16'hFFFF);
    read_reg(4'd2, v); check("R8 id hi", v, 16'h0044);
    read_reg(4'd3, v); check("R8 id lo", v, 16'h1400);
    read_reg(4'd5, v); check("R8 partner", v, 16'h0DE0);
  endtask

  task automatic t_adv();
    logic [15:0] v;
    write_reg(4'd4, 16'hA5E1);
    check("R12 data kept after write", data_q, 16'hA5E1);
    read_reg(4'd4, v); check("R9 adv readback", v, 16'hA5E1);
  endtask

  task automatic t_unknown();
    logic [15:0] v;
    write_reg(4'd7, 16'h1234);
    read_reg(4'd7, v); check("R10 reg7", v, 16'h0000);
    read_reg(4'd15, v); check("R10 reg15", v, 16'h0000);
    write_reg(4'd1, 16'h0000);
    read_reg(4'd1, v); check("R10 status write ignored", v, 16'hFE2C);
  endtask

  task automatic t_collide();
    @(negedge clk);
    data_wdata = 16'h5555;
    data_wr = 1'b1;
    cmd_wdata = mk_cmd(MY_PHY, 4'd3, 1'b0);
    cmd_wr = 1'b1;
    @(negedge clk);
    data_wr = 1'b0;
    cmd_wr = 1'b0;
    check("R11 read wins same edge", data_q, 16'h1400);
  endtask

  initial begin
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);
    t_reset();
    t_foreign();
    t_link();
    t_ctrl();
    t_fixed();
    t_adv();
    t_unknown();
    t_collide();
    if (!finished) begin
      finished = 1;
      $display("  test done: total=%0d bad=%0d", total, bad);
      $finish;
    end
  end

  initial begin
    repeat (20000) @(posedge clk);
    if (!finished) begin
      finished = 1;
      total++;
      bad++;
      $display("FAIL watchdog: actual=timeout expected=completion");
      $display("  test done: total=%0d bad=%0d", total, bad);
      $finish;
    end
  end
endmodule